// File: doc/BRIEF.md
# Priority-Based Throttle Request Arbiter

This block merges several independent throttle requests (light and heavy thermal events, overcurrent alarms and similar sources) into one final throttle setting. Each source is a plain on/off request bit. Each source also has its own configuration word that holds three values: a priority, a CPU clock throttle depth in percent, and a GPU throttle level.

On every clock, the block looks at the sources whose request bit is set and whose priority is legal. It picks the one with the largest priority number. The chosen source's CPU depth and GPU level go out as the final setting, together with a valid flag and the index of the winning source. The choice depends only on the programmed priorities. It does not depend on the order of the inputs or on which source asks for the deepest throttle.

Configuration goes through a small write port with an address, a data word and a write enable. There is one configuration word per source.

Top module: `throttle_prio_arbiter`

## Requirements
- R1: After reset, `thr_valid_o` is 0, `thr_src_o` is 0, `thr_cpu_o` is 0 and `thr_gpu_o` is 0 (GPU level NONE). Every source's priority is 0, so every source is disabled until it is written.
- R2: Among the active, enabled sources, the one with the largest priority number wins. Its CPU depth, GPU level and index appear on the outputs, and `thr_valid_o` is 1.
- R3: When two or more active, enabled sources share the highest priority, the source with the lower index wins.
- R4: A source with priority 0, or with priority above 100, never wins, whatever its request bit says.
- R5: When no enabled source is requesting, `thr_valid_o` is 0, `thr_src_o` is 0, `thr_cpu_o` is 0 and `thr_gpu_o` is 0.
- R6: The outputs are registered. A change on `req_i` is visible on the outputs after exactly one rising clock edge.
- R7: When `cfg_we_i` is high on a rising edge, the word at `cfg_addr_i` is written with this layout: priority in `cfg_wdata_i[6:0]`, CPU depth in percent in `[13:7]`, GPU level in `[15:14]`. The GPU level codes are 0 = NONE, 1 = LOW, 2 = MED and 3 = HIGH. The new value takes part in the selection from the next edge on, so it reaches the outputs one edge after the write.
- R8: The CPU depth and GPU level of the winner are passed through without change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | NSRC | One on/off throttle request bit per source |
| cfg_we_i | input | 1 | Configuration write enable |
| cfg_addr_i | input | IDX_W | Source index to write |
| cfg_wdata_i | input | 16 | Configuration word: {gpu[1:0], cpu[6:0], prio[6:0]} |
| thr_valid_o | output | 1 | A source is currently selected |
| thr_src_o | output | IDX_W | Index of the winning source |
| thr_cpu_o | output | 7 | Final CPU throttle depth in percent |
| thr_gpu_o | output | 2 | Final GPU throttle level |

## Verification
A configuration write and a change of the request bits can land in the same cycle. In that case the selection still uses the old configuration words, and the write only counts from the following edge.

The bench provokes this with a reprogramming case. Source 1 first wins while it is requesting. It is then disabled while its request stays high, and later its priority is raised again so that it wins back. For each step, the bench predicts the cycle in which the winner must change and checks the outputs in that cycle.

A second overlap is a tie in priority that arrives together with a higher-priority request. The stimulus table covers it with request patterns in which several sources turn on at once.

// File: rtl/throttle_prio_arbiter.sv
module throttle_prio_arbiter #(
  parameter int NSRC     = 4,
  parameter int PRIO_W   = 7,
  parameter int CPU_W    = 7,
  parameter int GPU_W    = 2,
  parameter int PRIO_MAX = 100,
  localparam int IDX_W   = (NSRC > 1) ? $clog2(NSRC) : 1,
  localparam int CFG_W   = PRIO_W + CPU_W + GPU_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NSRC-1:0]   req_i,
  input  logic              cfg_we_i,
  input  logic [IDX_W-1:0]  cfg_addr_i,
  input  logic [CFG_W-1:0]  cfg_wdata_i,
  output logic              thr_valid_o,
  output logic [IDX_W-1:0]  thr_src_o,
  output logic [CPU_W-1:0]  thr_cpu_o,
  output logic [GPU_W-1:0]  thr_gpu_o
);

  localparam logic [PRIO_W-1:0] PMAX = PRIO_W'(PRIO_MAX);

  logic [PRIO_W-1:0] prio_q [NSRC];
  logic [CPU_W-1:0]  cpu_q  [NSRC];
  logic [GPU_W-1:0]  gpu_q  [NSRC];
  logic [NSRC-1:0]   en;

  logic              win_v;
  logic [IDX_W-1:0]  win_i;
  logic [PRIO_W-1:0] best;

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        prio_q[g] <= '0;
        cpu_q[g]  <= '0;
        gpu_q[g]  <= '0;
      end else if (cfg_we_i && cfg_addr_i == IDX_W'(g)) begin
        prio_q[g] <= cfg_wdata_i[PRIO_W-1:0];
        cpu_q[g]  <= cfg_wdata_i[PRIO_W +: CPU_W];
        gpu_q[g]  <= cfg_wdata_i[PRIO_W+CPU_W +: GPU_W];
      end
    end
    assign en[g] = (prio_q[g] != '0) && (prio_q[g] <= PMAX);
  end

  always_comb begin
    win_v = 1'b0;
    win_i = '0;
    best  = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (req_i[i] && en[i] && (!win_v || prio_q[i] > best)) begin
        win_v = 1'b1;
        win_i = IDX_W'(i);
        best  = prio_q[i];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      thr_valid_o <= 1'b0;
      thr_src_o   <= '0;
      thr_cpu_o   <= '0;
      thr_gpu_o   <= '0;
    end else begin
      thr_valid_o <= win_v;
      thr_src_o   <= win_v ? win_i : '0;
      thr_cpu_o   <= win_v ? cpu_q[win_i] : '0;
      thr_gpu_o   <= win_v ? gpu_q[win_i] : '0;
    end
  end

  // R5, R6: no enabled request on the last edge means no valid output now
  a_r5_idle_output: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(req_i & en) == '0) |-> (!thr_valid_o && thr_cpu_o == '0 && thr_gpu_o == '0));

  // R2: a reported winner was requesting on the previous edge
  a_r2_winner_requested: assert property (@(posedge clk_i) disable iff (!rst_ni)
    thr_valid_o |-> ((($past(req_i) >> thr_src_o) & NSRC'(1)) != '0));

  // R4: a reported winner had a legal priority on the previous edge
  a_r4_winner_enabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    thr_valid_o |-> ((($past(en) >> thr_src_o) & NSRC'(1)) != '0));

  // R6: any enabled request on the previous edge yields a valid output
  a_r6_valid_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(req_i & en) != '0) |-> thr_valid_o);

  // R7: a write lands in the addressed priority field
  a_r7_write_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(cfg_we_i)) |->
      (prio_q[$past(cfg_addr_i)] == $past(cfg_wdata_i[PRIO_W-1:0])));

endmodule

// File: tb/tb_throttle_prio_arbiter.sv
`timescale 1ns/1ps
module tb_throttle_prio_arbiter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] req = '0;
  logic       we = 1'b0;
  logic [1:0] addr = '0;
  logic [15:0] wdata = '0;
  logic       valid;
  logic [1:0] src;
  logic [6:0] cpu;
  logic [1:0] gpu;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  throttle_prio_arbiter dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req),
    .cfg_we_i(we), .cfg_addr_i(addr), .cfg_wdata_i(wdata),
    .thr_valid_o(valid), .thr_src_o(src), .thr_cpu_o(cpu), .thr_gpu_o(gpu)
  );

  // {req[3:0], valid, src[1:0], cpu[6:0], gpu[1:0]}
  localparam int NV = 10;
  localparam logic [15:0] VEC [NV] = '{
    {4'b0000, 1'b0, 2'd0, 7'd0,  2'd0},
    {4'b0001, 1'b1, 2'd0, 7'd50, 2'd1},
    {4'b0010, 1'b1, 2'd1, 7'd85, 2'd3},
    {4'b0011, 1'b1, 2'd1, 7'd85, 2'd3},
    {4'b0100, 1'b1, 2'd2, 7'd75, 2'd2},
    {4'b0101, 1'b1, 2'd0, 7'd50, 2'd1},
    {4'b1001, 1'b1, 2'd0, 7'd50, 2'd1},
    {4'b1000, 1'b1, 2'd3, 7'd30, 2'd2},
    {4'b1100, 1'b1, 2'd3, 7'd30, 2'd2},
    {4'b1111, 1'b1, 2'd1, 7'd85, 2'd3}
  };

  task automatic check(string tag, logic ev, logic [1:0] es, logic [6:0] ec, logic [1:0] eg);
    checks++;
    if (valid !== ev || src !== es || cpu !== ec || gpu !== eg) begin
      fails++;
      $display("FAIL %s: got v=%0b src=%0d cpu=%0d gpu=%0d, expected v=%0b src=%0d cpu=%0d gpu=%0d",
               tag, valid, src, cpu, gpu, ev, es, ec, eg);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [6:0] p, logic [6:0] c, logic [1:0] g);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = {g, c, p};
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic step(logic [3:0] r);
    @(negedge clk);
    req = r;
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset outputs", 1'b0, 2'd0, 7'd0, 2'd0);
    rst_n = 1'b1;
    step(4'b1111);
    check("R1 unwritten sources disabled", 1'b0, 2'd0, 7'd0, 2'd0);

    wr(2'd0, 7'd80,  7'd50, 2'd1);
    wr(2'd1, 7'd100, 7'd85, 2'd3);
    wr(2'd2, 7'd50,  7'd75, 2'd2);
    wr(2'd3, 7'd80,  7'd30, 2'd2);

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][15:12]);
      check($sformatf("R2 R3 R5 R8 vector %0d", i),
            VEC[i][11], VEC[i][10:9], VEC[i][8:2], VEC[i][1:0]);
    end

    // R6: one-edge latency
    step(4'b0000);
    @(negedge clk);
    req = 4'b0010;
    #1 check("R6 before edge", 1'b0, 2'd0, 7'd0, 2'd0);
    @(negedge clk);
    check("R6 after one edge", 1'b1, 2'd1, 7'd85, 2'd3);

    // R4 / R7: disable source 1 while it is requesting
    req = 4'b1111;
    @(negedge clk);
    we = 1'b1; addr = 2'd1; wdata = {2'd3, 7'd85, 7'd0};
    #1 check("R7 write not yet effective", 1'b1, 2'd1, 7'd85, 2'd3);
    @(negedge clk);
    we = 1'b0;
    check("R7 selection still one edge behind", 1'b1, 2'd1, 7'd85, 2'd3);
    @(negedge clk);
    check("R4 priority 0 never wins", 1'b1, 2'd0, 7'd50, 2'd1);

    wr(2'd1, 7'd101, 7'd85, 2'd3);
    @(negedge clk);
    check("R4 priority 101 never wins", 1'b1, 2'd0, 7'd50, 2'd1);
    wr(2'd1, 7'd127, 7'd85, 2'd3);
    @(negedge clk);
    check("R4 priority 127 never wins", 1'b1, 2'd0, 7'd50, 2'd1);
    step(4'b0010);
    check("R4 R5 only disabled source active", 1'b0, 2'd0, 7'd0, 2'd0);

    wr(2'd1, 7'd100, 7'd9, 2'd0);
    @(negedge clk);
    check("R7 R8 rewritten fields", 1'b1, 2'd1, 7'd9, 2'd0);

    // R3: source 2 raised to 80 ties with sources 0 and 3
    wr(2'd2, 7'd80, 7'd75, 2'd2);
    step(4'b1100);
    check("R3 tie 2 vs 3", 1'b1, 2'd2, 7'd75, 2'd2);
    step(4'b1101);
    check("R3 tie 0 vs 2 vs 3", 1'b1, 2'd0, 7'd50, 2'd1);

    // R1: reset clears configuration
    @(negedge clk);
    rst_n = 1'b0;
    #1 check("R1 reset mid-run", 1'b0, 2'd0, 7'd0, 2'd0);
    @(negedge clk);
    rst_n = 1'b1;
    step(4'b1111);
    check("R1 config cleared by reset", 1'b0, 2'd0, 7'd0, 2'd0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule